// File: doc/BRIEF.md
# Parallel-Bus Sampling Converter Digital Model

This block is a synthesizable, clocked model of the digital control side of a 16-bit sampling converter that has a parallel read bus. A falling edge on the convert-start pin, taken while chip select is low and the block is acquiring, samples a supplied word (`sample`, which stands in for the analog front end). It raises `busy` for a fixed number of clock cycles and then publishes that word as the new conversion result. The result register keeps the previous conversion's value until the new conversion completes.

The read side presents the result while both chip select and read are low. It uses a value/enable pair that a pad ring turns into a three-state bus. A byte-select pin folds the low byte of the result onto the upper bus lines for 8-bit hosts. A conversion can be cancelled in three ways: an asynchronous active-low hard reset, a second convert edge while busy, or a chip-select edge while busy. Each of these clears the result. Every control pin passes through a two-flop synchronizer, and edges are found on the synchronized copies.

Top module: `sar_bus_model`

## Requirements
- R1: A conversion starts only on a synchronized falling edge of `convst_n` seen while the synchronized `cs_n` is low and the block is acquiring. A falling edge with `cs_n` high leaves `busy` low.
- R2: `busy` rises on the third rising clock edge after `convst_n` is driven low. It stays high for exactly `CONV_CYC` cycles, then drops, and the captured word becomes the result.
- R3: `db_oe` is 1 only while synchronized `cs_n` and `rd_n` are both low. For the three other combinations it is 0, and 0 means high impedance.
- R4: With `byte_sel` = 0 and `db_oe` = 1, `db_val[15:0]` equals the 16-bit result, MSB on bit 15, straight binary.
- R5: With `byte_sel` = 1 and `db_oe` = 1, `db_val[15:8]` equals result bits 7..0 and `db_val[7:0]` is 8'hFF.
- R6: A low level on `adc_rst_n` acts whatever the state of `cs_n`. It ends any conversion (`busy` = 0) and clears the result to 16'h0000.
- R7: While busy, a synchronized `cs_n` falling edge, or a `convst_n` falling edge with `cs_n` low, aborts the conversion and clears the result. This happens only if it arrives fewer than `ABORT_WIN` cycles into the conversion. A later edge is ignored and the conversion completes.
- R8: Until a conversion finishes, the result (and so `db_val`) keeps the previous conversion's value, even if `sample` changes.
- R9: After a hard reset or an abort, acquisition resumes only after `HOLD_CYC` cycles, and a convert edge before then is ignored. After a normal conversion, acquisition starts when `busy` falls with `cs_n` low, or else at the next `cs_n` falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock; also times conversion and hold-off |
| rst | input | 1 | Synchronous active-high system reset |
| convst_n | input | 1 | Convert start, falling edge samples |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| byte_sel | input | 1 | 1 folds result low byte onto bus bits 15..8 |
| adc_rst_n | input | 1 | Asynchronous active-low hard reset of the converter |
| sample | input | DW | Word captured at conversion start |
| busy | output | 1 | High while a conversion runs |
| db_oe | output | 1 | Bus drive enable; 0 means high impedance |
| db_val | output | DW | Value driven onto the bus when enabled |

## Verification
The hardest case to reach is an abort that lands inside the window. Chip select has to rise and fall again, or convert has to fall a second time, and the resulting synchronized edge must reach the sequencer within a few cycles of the start of the conversion. The bench counts clock edges from the convert drive, so it places these edges at a known conversion count. It also places one edge just past the window so that the abort is ignored. The hold-off after an abort or hard reset is probed the same way, with a convert edge timed to land before acquisition resumes.

// File: rtl/sar_bus_pkg.sv
package sar_bus_pkg;

    localparam int CTL_W = 5;

    // Synchronized control pins; field order fixes the bit packing.
    typedef struct packed {
        logic conv_n;
        logic sel_n;
        logic rd_n;
        logic hi_byte;
        logic hrst_n;
    } ctl_t;

    localparam ctl_t CTL_IDLE = '{conv_n: 1'b1, sel_n: 1'b1, rd_n: 1'b1,
                                  hi_byte: 1'b0, hrst_n: 1'b1};

    typedef enum logic [1:0] {
        ST_HOLDOFF,
        ST_WAIT,
        ST_ACQ,
        ST_CONV
    } seq_st_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sar_sync_bank.sv
module sar_sync_bank #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q, stab_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= RST_VAL[i];
                stab_q <= RST_VAL[i];
            end else begin
                meta_q <= d[i];
                stab_q <= meta_q;
            end
        end
        assign q[i] = stab_q;
    end
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
    import sar_bus_pkg::*;
#(
    parameter int DW        = 16,
    parameter int CONV_CYC  = 40,
    parameter int ABORT_WIN = 34,
    parameter int HOLD_CYC  = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          conv_n,
    input  logic          sel_n,
    input  logic          hrst_n,
    input  logic [DW-1:0] sample,
    output logic          busy,
    output logic [DW-1:0] result
);
    localparam int CNT_MAX = max2(CONV_CYC, HOLD_CYC);
    localparam int CW      = $clog2(CNT_MAX + 1);

    seq_st_e       st_q;
    logic [CW-1:0] cnt_q;
    logic [DW-1:0] hold_q, res_q;
    logic          conv_prev_q, sel_prev_q;
    logic          conv_fall, sel_fall, abort_req, in_window;

    assign conv_fall = conv_prev_q & ~conv_n;
    assign sel_fall  = sel_prev_q & ~sel_n;
    assign abort_req = sel_fall | (conv_fall & ~sel_n);
    assign in_window = cnt_q < CW'(ABORT_WIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_HOLDOFF;
            cnt_q       <= '0;
            hold_q      <= '0;
            res_q       <= '0;
            conv_prev_q <= 1'b1;
            sel_prev_q  <= 1'b1;
        end else begin
            conv_prev_q <= conv_n;
            sel_prev_q  <= sel_n;
            if (!hrst_n) begin
                st_q   <= ST_HOLDOFF;
                cnt_q  <= '0;
                hold_q <= '0;
                res_q  <= '0;
            end else begin
                unique case (st_q)
                    ST_HOLDOFF: begin
                        if (cnt_q == CW'(HOLD_CYC - 1)) begin
                            st_q  <= ST_ACQ;
                            cnt_q <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    ST_WAIT: begin
                        if (sel_fall) st_q <= ST_ACQ;
                    end
                    ST_ACQ: begin
                        if (conv_fall && !sel_n) begin
                            st_q   <= ST_CONV;
                            cnt_q  <= '0;
                            hold_q <= sample;
                        end
                    end
                    ST_CONV: begin
                        if (abort_req && in_window) begin
                            st_q   <= ST_HOLDOFF;
                            cnt_q  <= '0;
                            hold_q <= '0;
                            res_q  <= '0;
                        end else if (cnt_q == CW'(CONV_CYC - 1)) begin
                            res_q <= hold_q;
                            cnt_q <= '0;
                            st_q  <= sel_n ? ST_WAIT : ST_ACQ;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: st_q <= ST_HOLDOFF;
                endcase
            end
        end
    end

    assign busy   = (st_q == ST_CONV);
    assign result = res_q;
endmodule

// File: rtl/sar_bus_fmt.sv
module sar_bus_fmt #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] result,
    input  logic          sel_n,
    input  logic          rd_n,
    input  logic          hi_byte,
    output logic          oe,
    output logic [DW-1:0] val
);
    localparam int HALF = DW / 2;

    logic [DW-1:0] folded;
    assign folded = {result[HALF-1:0], {(DW - HALF){1'b1}}};
    assign oe     = ~sel_n & ~rd_n;
    assign val    = !oe ? '0 : (hi_byte ? folded : result);
endmodule

// File: rtl/sar_bus_model.sv
module sar_bus_model
    import sar_bus_pkg::*;
#(
    parameter int DW        = 16,
    parameter int CONV_CYC  = 40,
    parameter int ABORT_WIN = 34,
    parameter int HOLD_CYC  = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          convst_n,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          byte_sel,
    input  logic          adc_rst_n,
    input  logic [DW-1:0] sample,
    output logic          busy,
    output logic          db_oe,
    output logic [DW-1:0] db_val
);
    ctl_t          ctl_raw, ctl_s;
    logic [DW-1:0] result_q;
    logic          sel_s, rd_s, hi_s, hrst_s;

    always_comb begin
        ctl_raw.conv_n  = convst_n;
        ctl_raw.sel_n   = cs_n;
        ctl_raw.rd_n    = rd_n;
        ctl_raw.hi_byte = byte_sel;
        ctl_raw.hrst_n  = adc_rst_n;
    end

    sar_sync_bank #(.W(CTL_W), .RST_VAL(CTL_IDLE)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (ctl_raw),
        .q   (ctl_s)
    );

    assign sel_s  = ctl_s.sel_n;
    assign rd_s   = ctl_s.rd_n;
    assign hi_s   = ctl_s.hi_byte;
    assign hrst_s = ctl_s.hrst_n;

    sar_conv_seq #(
        .DW(DW), .CONV_CYC(CONV_CYC), .ABORT_WIN(ABORT_WIN), .HOLD_CYC(HOLD_CYC)
    ) u_seq (
        .clk    (clk),
        .rst    (rst),
        .conv_n (ctl_s.conv_n),
        .sel_n  (sel_s),
        .hrst_n (hrst_s),
        .sample (sample),
        .busy   (busy),
        .result (result_q)
    );

    sar_bus_fmt #(.DW(DW)) u_fmt (
        .result  (result_q),
        .sel_n   (sel_s),
        .rd_n    (rd_s),
        .hi_byte (hi_s),
        .oe      (db_oe),
        .val     (db_val)
    );
endmodule

// File: rtl/sar_bus_chk.sv
module sar_bus_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          cs_n,
    input logic          rd_n,
    input logic          busy,
    input logic          sel_s,
    input logic          hi_s,
    input logic          hrst_s,
    input logic          db_oe,
    input logic [DW-1:0] db_val,
    input logic [DW-1:0] result
);
    localparam int HALF = DW / 2;

    p_start_cs_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !$past(sel_s));

    p_oe_pins_r3: assert property (@(posedge clk) disable iff (rst)
        db_oe |-> (!$past(cs_n, 2) && !$past(rd_n, 2)));

    p_fold_r5: assert property (@(posedge clk) disable iff (rst)
        (db_oe && hi_s) |-> (db_val == {result[HALF-1:0], {(DW - HALF){1'b1}}}));

    p_hard_clear_r6: assert property (@(posedge clk) disable iff (rst)
        !hrst_s |=> (!busy && result == '0));

    p_keep_prev_r8: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!busy || $stable(result)));
endmodule

bind sar_bus_model sar_bus_chk #(.DW(DW)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .cs_n   (cs_n),
    .rd_n   (rd_n),
    .busy   (busy),
    .sel_s  (sel_s),
    .hi_s   (hi_s),
    .hrst_s (hrst_s),
    .db_oe  (db_oe),
    .db_val (db_val),
    .result (result_q)
);

// File: tb/tb_sar_bus_model.sv
module tb_sar_bus_model;
    localparam int DW   = 16;
    localparam int CONV = 12;
    localparam int WIN  = 6;
    localparam int HOLD = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          convst_n = 1'b1, cs_n = 1'b1, rd_n = 1'b1;
    logic          byte_sel = 1'b0, adc_rst_n = 1'b1;
    logic [DW-1:0] sample = '0;
    logic          busy, db_oe;
    logic [DW-1:0] db_val;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [DW-1:0] last;

    always #5 clk = ~clk;

    sar_bus_model #(.DW(DW), .CONV_CYC(CONV), .ABORT_WIN(WIN), .HOLD_CYC(HOLD)) dut (
        .clk(clk), .rst(rst), .convst_n(convst_n), .cs_n(cs_n), .rd_n(rd_n),
        .byte_sel(byte_sel), .adc_rst_n(adc_rst_n), .sample(sample),
        .busy(busy), .db_oe(db_oe), .db_val(db_val)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Full conversion with edge-exact timing checks; cs_n and rd_n low.
    task automatic convert(input logic [DW-1:0] w);
        convst_n = 1'b0;
        sample   = w;
        step(2);
        chk("R2 busy low before third edge", 32'(busy), 32'd0);
        step(1);
        chk("R2 busy high on third edge", 32'(busy), 32'd1);
        convst_n = 1'b1;
        sample   = ~w;
        step(CONV - 1);
        chk("R2 busy held", 32'(busy), 32'd1);
        chk("R8 previous result kept", 32'(db_val), 32'(last));
        step(1);
        chk("R2 busy dropped", 32'(busy), 32'd0);
        chk("R4 full word", 32'(db_val), 32'(w));
        last = w;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        last = '0;
        step(3);
        rst = 1'b0;
        step(1);
        chk("R3 reset oe", 32'(db_oe), 32'd0);
        chk("R2 reset busy", 32'(busy), 32'd0);
        step(HOLD + 5);
        cs_n = 1'b0;
        rd_n = 1'b0;
        step(3);
        chk("R3 oe with cs and rd low", 32'(db_oe), 32'd1);
        chk("R6 result starts at zero", 32'(db_val), 32'd0);

        // Sweep of words in both read formats.
        for (int i = 0; i < 16; i++) begin
            logic [DW-1:0] w;
            w = (i == 0) ? 16'h0000 : (i == 1) ? 16'hFFFF :
                (i == 2) ? 16'h8000 : (i == 3) ? 16'h7FFF : 16'(i * 40503 + 7);
            convert(w);
            byte_sel = 1'b1;
            step(3);
            chk("R5 folded low byte", 32'(db_val), 32'({w[7:0], 8'hFF}));
            byte_sel = 1'b0;
            step(3);
            chk("R4 unfolded again", 32'(db_val), 32'(w));
        end

        // R3: the other three cs/rd combinations.
        for (int k = 1; k < 4; k++) begin
            cs_n = k[1];
            rd_n = k[0];
            step(3);
            chk("R3 bus released", 32'(db_oe), 32'd0);
        end
        cs_n = 1'b0;
        rd_n = 1'b0;
        step(3);
        chk("R3 bus driven", 32'(db_oe), 32'd1);

        // R1: convert edge with chip select high is ignored.
        cs_n = 1'b1;
        step(3);
        convst_n = 1'b0;
        step(5);
        chk("R1 no start with cs high", 32'(busy), 32'd0);
        convst_n = 1'b1;
        cs_n = 1'b0;
        step(3);
        chk("R1 result untouched", 32'(db_val), 32'(last));
        convert(16'h1234);

        // R7: abort via chip select edge inside window.
        convst_n = 1'b0;
        sample = 16'hBEEF;
        step(3);
        chk("R7 busy before cs abort", 32'(busy), 32'd1);
        convst_n = 1'b1;
        cs_n = 1'b1;
        step(1);
        cs_n = 1'b0;
        step(3);
        chk("R7 cs abort busy", 32'(busy), 32'd0);
        chk("R7 cs abort clears", 32'(db_val), 32'd0);
        last = '0;
        // R9: convert edge during hold-off is ignored.
        convst_n = 1'b0;
        step(5);
        chk("R9 no start during hold-off", 32'(busy), 32'd0);
        convst_n = 1'b1;
        step(HOLD + 3);
        convert(16'h5A5A);

        // R7: abort via second convert edge inside window.
        convst_n = 1'b0;
        sample = 16'hC0DE;
        step(3);
        convst_n = 1'b1;
        step(1);
        convst_n = 1'b0;
        step(3);
        chk("R7 convst abort busy", 32'(busy), 32'd0);
        chk("R7 convst abort clears", 32'(db_val), 32'd0);
        last = '0;
        convst_n = 1'b1;
        step(HOLD + 4);

        // R7: convert edge past the window is ignored.
        convst_n = 1'b0;
        sample = 16'h2468;
        step(3);
        convst_n = 1'b1;
        step(7);
        convst_n = 1'b0;
        step(4);
        chk("R7 late edge ignored", 32'(busy), 32'd1);
        step(1);
        chk("R7 late conversion completes", 32'(busy), 32'd0);
        chk("R7 late result", 32'(db_val), 32'h2468);
        last = 16'h2468;
        convst_n = 1'b1;
        step(3);

        // R6: hard reset mid conversion, chip select high.
        convst_n = 1'b0;
        sample = 16'h9999;
        step(3);
        convst_n = 1'b1;
        cs_n = 1'b1;
        adc_rst_n = 1'b0;
        step(4);
        chk("R6 hard reset ends busy", 32'(busy), 32'd0);
        cs_n = 1'b0;
        step(3);
        chk("R6 hard reset clears", 32'(db_val), 32'd0);
        last = '0;
        adc_rst_n = 1'b1;
        step(2);
        convst_n = 1'b0;
        step(4);
        chk("R9 no start after hard reset", 32'(busy), 32'd0);
        convst_n = 1'b1;
        step(HOLD + 4);
        convert(16'h0F0F);

        // R9: conversion ends with cs high -> waits for cs edge.
        convst_n = 1'b0;
        sample = 16'h3C3C;
        step(3);
        convst_n = 1'b1;
        step(WIN + 1);
        cs_n = 1'b1;
        step(CONV);
        convst_n = 1'b0;
        step(2);
        cs_n = 1'b0;
        step(4);
        chk("R9 no start without acquisition", 32'(busy), 32'd0);
        convst_n = 1'b1;
        step(3);
        chk("R9 result after cs-high end", 32'(db_val), 32'h3C3C);
        last = 16'h3C3C;
        convert(16'hA5C3);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule